// File: doc/BRIEF.md
# Serial Divider-Word Loader for a Frequency Synthesizer

This block takes a three-wire serial programming stream and turns it into the parallel divide settings of a frequency synthesizer. A host holds the active-low enable line low. It presents one data bit per serial clock, most significant bit first, and then raises enable. The length of the burst chooses the destination. Eight bits go to the control word. Sixteen bits go to the reference divide value. Twenty-four bits go to the loop divider, which carries a 12-bit main count and a 6-bit swallow count. A burst of any other length is dropped.

The reference divide value passes through a staging buffer. It is copied to the active output only on a terminal-count pulse from the external reference counter, so that counter never sees a division ratio change part way through a cycle. A serial output repeats the most significant bit of the 24-bit shift chain, which allows devices to be chained or the chain to be read back.

All serial inputs are sampled in the system clock domain through two-stage synchronizers. The serial side has no handshake and applies no back-pressure. The host must hold every level for at least three system clocks. Each register update raises a one-cycle load strobe. The stream itself uses no valid/ready pair.

Top module: `ssp_loader`

## Requirements
- R1: After reset, the control, active reference, staged reference, N and A outputs are all zero, `ser_out` is 0 and every load strobe is low.
- R2: Each rising edge of `ser_clk` seen while `ser_en_n` is low shifts `ser_din` into bit 0 of a 24-bit chain. Bits move toward bit 23, so the first bit of a burst is the most significant. `ser_out` always shows chain bit 23.
- R3: Serial clock edges while `ser_en_n` is high shift nothing and count nothing. `ser_out` and all registers keep their values.
- R4: On the rising edge of `ser_en_n`, if exactly 8 bits were shifted, `ctrl_q` takes those 8 bits and `ctrl_ld` pulses.
- R5: If exactly 24 bits were shifted, `div_n_q` takes burst bits [23:12] and `div_a_q` takes burst bits [5:0]. Burst bits [11:6] are dropped, and `div_ld` pulses.
- R6: If exactly 16 bits were shifted, the value goes to the staging buffer only. `ref_q` stays unchanged until a `ref_tc` pulse arrives while a staged value is pending. `ref_q` then updates and `ref_ld` pulses on the following cycle. A `ref_tc` pulse with nothing pending has no effect.
- R7: A burst of any other length, including 0, 7, 9, 25 and lengths well above 24, changes no register and raises no strobe.
- R8: Every load strobe lasts exactly one system clock, and each update produces one strobe.
- R9: When two 16-bit bursts arrive before a `ref_tc` pulse, the later value is the one that reaches `ref_q`. A single `ref_ld` pulse marks the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data, MSB first |
| ser_en_n | input | 1 | Active-low burst enable; rising edge commits |
| ref_tc | input | 1 | Terminal-count pulse from the reference counter |
| ser_out | output | 1 | Most significant bit of the shift chain |
| ctrl_q | output | 8 | Control word |
| ref_q | output | 16 | Active reference divide value |
| div_n_q | output | 12 | Main divider count |
| div_a_q | output | 6 | Swallow count |
| ctrl_ld | output | 1 | One-cycle strobe on control update |
| ref_ld | output | 1 | One-cycle strobe on active reference update |
| div_ld | output | 1 | One-cycle strobe on divider update |

## Verification
The assertions check four things on every cycle. Each register holds its value unless its own strobe is high. `ref_ld` only ever follows a terminal-count pulse. Strobes never last two cycles. The shift chain is frozen while enable is high. Other behaviour can only be shown by the bench's scenarios: that burst length picks the destination, that the divider fields are split correctly, that odd lengths and overlong bursts are dropped, and that the later staged reference value wins. These need a whole serial burst and a model of the expected words.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_CTRL = 2'd1,
    DST_REF  = 2'd2,
    DST_DIV  = 2'd3
  } dest_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_r, stab_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_r <= 1'b0;
        stab_r <= 1'b0;
      end else begin
        meta_r <= d[i];
        stab_r <= meta_r;
      end
    end
    assign q[i] = stab_r;
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int CHAIN_W = 24,
  parameter int CTRL_W  = 8,
  parameter int REF_W   = 16,
  parameter int N_W     = 12,
  parameter int A_W     = 6,
  parameter int CNT_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  input  logic              clr,
  output logic              msb_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [REF_W-1:0]  ref_o,
  output logic [N_W-1:0]    n_o,
  output logic [A_W-1:0]    a_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CHAIN_W-1:0] chain_r;
  logic [CNT_W-1:0]   cnt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_r <= '0;
    end else if (shift_en) begin
      chain_r <= {chain_r[CHAIN_W-2:0], din};
    end
  end

  // bit counter saturates so overlong bursts never wrap onto a valid length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (clr) begin
      cnt_r <= '0;
    end else if (shift_en && (cnt_r != '1)) begin
      cnt_r <= cnt_r + 1'b1;
    end
  end

  assign msb_o  = chain_r[CHAIN_W-1];
  assign ctrl_o = chain_r[CTRL_W-1:0];
  assign ref_o  = chain_r[REF_W-1:0];
  assign n_o    = chain_r[CHAIN_W-1 -: N_W];
  assign a_o    = chain_r[A_W-1:0];
  assign cnt_o  = cnt_r;
endmodule

// File: rtl/ssp_regbank.sv
module ssp_regbank
  import ssp_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int REF_W  = 16,
  parameter int DIV_W  = 24,
  parameter int N_W    = 12,
  parameter int A_W    = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CTRL_W-1:0] ctrl_w,
  input  logic [REF_W-1:0]  ref_w,
  input  logic [N_W-1:0]    n_w,
  input  logic [A_W-1:0]    a_w,
  input  logic              ref_tc,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [REF_W-1:0]  ref_q,
  output logic [N_W-1:0]    n_q,
  output logic [A_W-1:0]    a_q,
  output logic              ctrl_ld,
  output logic              ref_ld,
  output logic              div_ld
);
  localparam logic [CNT_W-1:0] LEN_CTRL = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] LEN_REF  = CNT_W'(REF_W);
  localparam logic [CNT_W-1:0] LEN_DIV  = CNT_W'(DIV_W);

  dest_e            dest;
  logic [REF_W-1:0] stage_r;
  logic             pend_r;

  always_comb begin
    if (cnt == LEN_CTRL)     dest = DST_CTRL;
    else if (cnt == LEN_REF) dest = DST_REF;
    else if (cnt == LEN_DIV) dest = DST_DIV;
    else                     dest = DST_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ref_q   <= '0;
      stage_r <= '0;
      pend_r  <= 1'b0;
      n_q     <= '0;
      a_q     <= '0;
      ctrl_ld <= 1'b0;
      ref_ld  <= 1'b0;
      div_ld  <= 1'b0;
    end else begin
      ctrl_ld <= 1'b0;
      ref_ld  <= 1'b0;
      div_ld  <= 1'b0;
      // safe-point transfer of the staged reference value
      if (ref_tc && pend_r) begin
        ref_q  <= stage_r;
        ref_ld <= 1'b1;
        pend_r <= 1'b0;
      end
      if (commit) begin
        unique case (dest)
          DST_CTRL: begin
            ctrl_q  <= ctrl_w;
            ctrl_ld <= 1'b1;
          end
          DST_REF: begin
            stage_r <= ref_w;
            pend_r  <= 1'b1;
          end
          DST_DIV: begin
            n_q    <= n_w;
            a_q    <= a_w;
            div_ld <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: strobes are single-cycle
  assert_ctrl_ld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ld |=> !ctrl_ld);
  assert_div_ld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_ld |=> !div_ld);
  // R6: active reference moves only after a terminal-count pulse
  assert_ref_ld_after_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ld |-> $past(ref_tc));
  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ld |-> (ref_q == $past(ref_q)));
  // R4: control word holds unless strobed
  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ld |-> (ctrl_q == $past(ctrl_q)));
  // R5: divider fields hold unless strobed
  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ld |-> ({n_q, a_q} == $past({n_q, a_q})));
endmodule

// File: rtl/ssp_loader.sv
module ssp_loader #(
  parameter int CTRL_W = 8,
  parameter int REF_W  = 16,
  parameter int N_W    = 12,
  parameter int A_W    = 6,
  parameter int DIV_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_en_n,
  input  logic              ref_tc,
  output logic              ser_out,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [REF_W-1:0]  ref_q,
  output logic [N_W-1:0]    div_n_q,
  output logic [A_W-1:0]    div_a_q,
  output logic              ctrl_ld,
  output logic              ref_ld,
  output logic              div_ld
);
  localparam int CNT_W = $clog2(DIV_W) + 2;

  logic [2:0] raw_in, sync_q;
  logic       sclk_s, din_s, en_s;
  logic       sclk_prev, en_prev;
  logic       sclk_rise, en_rise, en_fall;
  logic       shift_en;

  logic [CTRL_W-1:0] ctrl_w;
  logic [REF_W-1:0]  ref_w;
  logic [N_W-1:0]    n_w;
  logic [A_W-1:0]    a_w;
  logic [CNT_W-1:0]  cnt;

  assign raw_in = {ser_en_n, ser_din, ser_clk};

  ssp_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  assign sclk_s = sync_q[0];
  assign din_s  = sync_q[1];
  assign en_s   = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      en_prev   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      en_prev   <= en_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign en_rise   = en_s & ~en_prev;
  assign en_fall   = ~en_s & en_prev;
  assign shift_en  = ~en_s & sclk_rise;

  ssp_shifter #(
    .CHAIN_W(DIV_W), .CTRL_W(CTRL_W), .REF_W(REF_W),
    .N_W(N_W), .A_W(A_W), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din_s),
    .clr(en_fall | en_rise), .msb_o(ser_out), .ctrl_o(ctrl_w),
    .ref_o(ref_w), .n_o(n_w), .a_o(a_w), .cnt_o(cnt)
  );

  ssp_regbank #(
    .CTRL_W(CTRL_W), .REF_W(REF_W), .DIV_W(DIV_W),
    .N_W(N_W), .A_W(A_W), .CNT_W(CNT_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(en_rise), .cnt(cnt),
    .ctrl_w(ctrl_w), .ref_w(ref_w), .n_w(n_w), .a_w(a_w),
    .ref_tc(ref_tc), .ctrl_q(ctrl_q), .ref_q(ref_q),
    .n_q(div_n_q), .a_q(div_a_q), .ctrl_ld(ctrl_ld),
    .ref_ld(ref_ld), .div_ld(div_ld)
  );

  // R3: with the synchronized enable high, the chain does not move
  assert_chain_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |=> $stable({ser_out, n_w, ref_w}));
endmodule

// File: tb/ssp_loader_bench.sv
module ssp_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_en_n = 1'b1, ref_tc = 1'b0;
  logic ser_out, ctrl_ld, ref_ld, div_ld;
  logic [7:0]  ctrl_q;
  logic [15:0] ref_q;
  logic [11:0] div_n_q;
  logic [5:0]  div_a_q;

  always #2.5 clk = ~clk;

  ssp_loader u_ssp_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_en_n(ser_en_n), .ref_tc(ref_tc), .ser_out(ser_out),
    .ctrl_q(ctrl_q), .ref_q(ref_q), .div_n_q(div_n_q), .div_a_q(div_a_q),
    .ctrl_ld(ctrl_ld), .ref_ld(ref_ld), .div_ld(div_ld)
  );

  typedef struct packed { logic [1:0] kind; logic [23:0] val; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  bit ref_pend = 0;
  logic [15:0] ref_stage = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic burst(input logic [127:0] bits, input int len);
    @(negedge clk) ser_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      ser_din = bits[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_en_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic load_ctrl(input logic [7:0] v);
    exp_q.push_back({2'd0, 16'h0, v});
    burst({120'h0, v}, 8);
  endtask

  task automatic load_div(input logic [23:0] v);
    exp_q.push_back({2'd2, 6'h0, v[23:12], v[5:0]});
    burst({104'h0, v}, 24);
  endtask

  task automatic load_ref(input logic [15:0] v);
    ref_pend = 1;
    ref_stage = v;
    burst({112'h0, v}, 16);
  endtask

  task automatic pulse_tc();
    if (ref_pend) begin
      exp_q.push_back({2'd1, 8'h0, ref_stage});
      ref_pend = 0;
    end
    @(negedge clk) ref_tc = 1'b1;
    @(negedge clk) ref_tc = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor
  logic [2:0] prev_stb = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] stb;
      stb = {div_ld, ref_ld, ctrl_ld};
      chk((stb & prev_stb) == 3'b0, "R8 strobe width", {29'h0, stb}, 32'h0);
      for (int k = 0; k < 3; k++) begin
        if (stb[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected strobe", k, 32'hFFFF_FFFF);
          end else begin
            item_t it;
            logic [23:0] act;
            it = exp_q.pop_front();
            act = (k == 0) ? {16'h0, ctrl_q} : (k == 1) ? {8'h0, ref_q} : {6'h0, div_n_q, div_a_q};
            chk(it.kind == 2'(k) && it.val == act,
                (k == 0) ? "R4 ctrl load" : (k == 1) ? "R6 ref transfer" : "R5 div load",
                {6'(k), act}, {6'(it.kind), it.val});
          end
        end
      end
      prev_stb = stb;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({ctrl_q, ref_q, div_n_q, div_a_q, ser_out, ctrl_ld, ref_ld, div_ld} == '0,
        "R1 reset", {ctrl_q, ref_q, ser_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    load_ctrl(8'hA5);
    chk(ctrl_q == 8'hA5, "R4 ctrl value", ctrl_q, 8'hA5);

    w = {12'h01B, 6'b101010, 6'b010110};
    load_div(w);
    chk(div_n_q == 12'h01B && div_a_q == 6'h16, "R5 N/A split", {div_n_q, div_a_q}, {12'h01B, 6'h16});
    chk(ser_out == w[23], "R2 ser_out after 24", ser_out, w[23]);

    // R3 clocks with enable high: nothing moves
    ser_din = 1'b1;
    for (int i = 0; i < 24; i++) begin
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(ser_out == w[23], "R3 ser_out frozen", ser_out, w[23]);
    chk(ctrl_q == 8'hA5 && div_n_q == 12'h01B, "R3 regs frozen", {ctrl_q, div_n_q}, {8'hA5, 12'h01B});

    load_ctrl(8'h3C);
    chk(ser_out == w[15], "R2 MSB-first chain", ser_out, w[15]);

    load_ref(16'hBEEF);
    chk(ref_q == 16'h0, "R6 staged not active", ref_q, 0);
    pulse_tc();
    chk(ref_q == 16'hBEEF, "R6 active after tc", ref_q, 16'hBEEF);
    pulse_tc();
    chk(ref_q == 16'hBEEF, "R6 tc with nothing pending", ref_q, 16'hBEEF);

    load_ref(16'h1234);
    load_ref(16'h5678);
    pulse_tc();
    chk(ref_q == 16'h5678, "R9 later stage wins", ref_q, 16'h5678);

    // R7 odd lengths
    burst(128'h55, 7);
    burst(128'h1FF, 9);
    burst(128'h1FF_FFFF, 25);
    burst({64'hFFFF_0000_FFFF_0000, 64'h0123_4567_89AB_CDEF}, 70);
    burst(128'h0, 0);
    chk(ctrl_q == 8'h3C && ref_q == 16'h5678 && div_n_q == 12'h01B && div_a_q == 6'h16,
        "R7 discard", {ctrl_q, ref_q, div_a_q}, {8'h3C, 16'h5678, 6'h16});

    load_div(24'hFFFFFF);
    chk(div_n_q == 12'hFFF && div_a_q == 6'h3F, "R5 all ones", {div_n_q, div_a_q}, {12'hFFF, 6'h3F});
    load_ctrl(8'h00);
    chk(ctrl_q == 8'h00, "R4 ctrl zero", ctrl_q, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every update strobed", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule